// File: doc/BRIEF.md
# Banked Two-Stream Parallel Merger

This block merges two sorted streams, A and B, into one stream. Both inputs and the output are in descending order. The merger emits W elements per cycle. Each input stream is spread over W banked FIFOs. Element k of a stream sits in bank k mod W. Every bank presents its head value together with its own valid flag, and the merger pops each bank individually through a per-bank dequeue strobe.

The first pipeline stage is made of W independent maximum units. Unit i compares the head of A bank i with the head of B bank W-1-i. It passes the larger value on and pops only the bank that supplied it. The W chosen values are the largest W still outstanding, arranged as a rotated bitonic sequence. A registered butterfly of log2(W) compare-and-swap layers then puts them in descending order.

A stream is terminated by feeding zeros after its last real element. When `bal_en` is high, ties alternate between the two sources in each unit, so that duplicate-heavy inputs drain both streams at a similar rate. The output side follows a valid/ready handshake, and backpressure freezes the entire pipeline.

Top module: `bank_merge2`

## Requirements
- R1: After a synchronous reset, `out_valid` is 0.
- R2: On every firing cycle, unit i pops exactly one bank, either A bank i or B bank W-1-i, so exactly W strobes are high across `a_deq` and `b_deq`.
- R3: When unit i's two heads differ under an unsigned comparison, it pops the bank holding the larger head.
- R4: With `bal_en` low, a unit whose two heads are equal pops the B bank.
- R5: With `bal_en` high, a unit whose two heads are equal pops the source it did not use on its previous selection. The first tie after reset goes to B.
- R6: No dequeue strobe is raised unless all 2W bank valids are high and the output is not stalled (`out_valid` high with `out_ready` low).
- R7: Each output chunk taken with `out_valid` and `out_ready` both high holds the next W elements of the descending merge of A and B. Element 0, in bits DW-1:0, is the largest.
- R8: The first output becomes valid log2(W)+1 cycles after the first firing cycle.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values.
- R10: Once all real elements have been emitted, the zero sentinels appear as all-zero output chunks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bal_en | input | 1 | Tie balancing between sources when high |
| a_data | input | W*DW | Heads of the A banks, bank i in bits i*DW +: DW |
| a_valid | input | W | Per-bank head valid for A |
| a_deq | output | W | Per-bank pop strobe for A |
| b_data | input | W*DW | Heads of the B banks |
| b_valid | input | W | Per-bank head valid for B |
| b_deq | output | W | Per-bank pop strobe for B |
| out_ready | input | 1 | Downstream accepts the current chunk |
| out_data | output | W*DW | Sorted output chunk, slot 0 largest |
| out_valid | output | 1 | Output chunk present |

## Verification
The following are checked by assertions on every cycle:
- that each unit pops exactly one bank of its mirrored pair, and that exactly W pops occur per firing cycle;
- that nothing is popped while any bank is empty or the output is stalled;
- that ties go to B in the basic mode;
- that every valid output chunk is in descending order;
- that a stalled output holds.

Some behaviours only the bench scenarios can show:
- that the chunks equal a reference merge;
- that the tie alternation in balanced mode follows each unit's history;
- the fill latency;
- that the zero sentinels flow out cleanly after the real data.

// File: rtl/bank_merge2_pkg.sv
package bank_merge2_pkg;
  // Selection rule of one maximum unit: the A head wins when larger, or
  // on a tie when balancing is on and the unit last took from B.
  function automatic logic bm_pick_a(input logic gt, input logic eq,
                                     input logic bal, input logic last_b);
    return gt | (eq & bal & last_b);
  endfunction
endpackage

// File: rtl/bank_merge2_maxu.sv
module bank_merge2_maxu
  import bank_merge2_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic          bal_en,
  input  logic [DW-1:0] a_head,
  input  logic [DW-1:0] b_head,
  output logic          a_pop,
  output logic          b_pop,
  output logic [DW-1:0] sel_q
);
  logic last_b;
  logic take_a;

  always_comb begin
    take_a = bm_pick_a(a_head > b_head, a_head == b_head, bal_en, last_b);
    a_pop  = fire & take_a;
    b_pop  = fire & ~take_a;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_b <= 1'b0;
      sel_q  <= '0;
    end else if (fire) begin
      last_b <= ~take_a;
      sel_q  <= take_a ? a_head : b_head;
    end
  end
endmodule

// File: rtl/bank_merge2_cas.sv
module bank_merge2_cas #(
  parameter int W  = 4,
  parameter int DW = 8,
  parameter int D  = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            in_vld,
  input  logic [W*DW-1:0] din,
  output logic            out_vld,
  output logic [W*DW-1:0] dout
);
  logic [W*DW-1:0] nxt;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_pair
      if (((i / D) % 2) == 0) begin : g_lo
        logic [DW-1:0] x, y;
        assign x = din[i*DW +: DW];
        assign y = din[(i+D)*DW +: DW];
        assign nxt[i*DW +: DW]     = (y > x) ? y : x;
        assign nxt[(i+D)*DW +: DW] = (y > x) ? x : y;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) out_vld <= 1'b0;
    else if (en) out_vld <= in_vld;
  end

  always_ff @(posedge clk) begin
    if (en) dout <= nxt;
  end
endmodule

// File: rtl/bank_merge2.sv
module bank_merge2 #(
  parameter int W  = 4,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bal_en,
  input  logic [W*DW-1:0] a_data,
  input  logic [W-1:0]    a_valid,
  output logic [W-1:0]    a_deq,
  input  logic [W*DW-1:0] b_data,
  input  logic [W-1:0]    b_valid,
  output logic [W-1:0]    b_deq,
  input  logic            out_ready,
  output logic [W*DW-1:0] out_data,
  output logic            out_valid
);
  localparam int LG = $clog2(W);

  logic            en;
  logic            fire;
  logic            v0;
  logic [W*DW-1:0] sel0;
  logic [W*DW-1:0] stg [0:LG];
  logic            vld [0:LG];

  assign en   = ~out_valid | out_ready;
  assign fire = en & (&a_valid) & (&b_valid);

  // Selector stage: unit i pairs A bank i with B bank W-1-i.
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_max
      bank_merge2_maxu #(.DW(DW)) u_max (
        .clk    (clk),
        .rst    (rst),
        .fire   (fire),
        .bal_en (bal_en),
        .a_head (a_data[i*DW +: DW]),
        .b_head (b_data[(W-1-i)*DW +: DW]),
        .a_pop  (a_deq[i]),
        .b_pop  (b_deq[W-1-i]),
        .sel_q  (sel0[i*DW +: DW])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) v0 <= 1'b0;
    else if (en) v0 <= fire;
  end

  assign stg[0] = sel0;
  assign vld[0] = v0;

  // Butterfly: distances W/2 down to 1.
  genvar s;
  generate
    for (s = 0; s < LG; s++) begin : g_stage
      bank_merge2_cas #(.W(W), .DW(DW), .D(W >> (s + 1))) u_cas (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .in_vld  (vld[s]),
        .din     (stg[s]),
        .out_vld (vld[s+1]),
        .dout    (stg[s+1])
      );
    end
  endgenerate

  assign out_data  = stg[LG];
  assign out_valid = vld[LG];
endmodule

// File: rtl/bank_merge2_chk.sv
module bank_merge2_chk #(
  parameter int W  = 4,
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            bal_en,
  input logic [W*DW-1:0] a_data,
  input logic [W-1:0]    a_valid,
  input logic [W-1:0]    a_deq,
  input logic [W*DW-1:0] b_data,
  input logic [W-1:0]    b_valid,
  input logic [W-1:0]    b_deq,
  input logic            out_ready,
  input logic [W*DW-1:0] out_data,
  input logic            out_valid
);
  logic go;
  assign go = (&a_valid) & (&b_valid) & (~out_valid | out_ready);

  // R1: reset empties the output
  a_r1_reset_empty: assert property (@(posedge clk) rst |=> !out_valid);

  // R2: exactly W pops per firing cycle
  a_r2_pop_count: assert property (@(posedge clk) disable iff (rst)
    go |-> ($countones({a_deq, b_deq}) == W));

  // R6: no pop while a bank is empty or output stalled
  a_r6_no_pop_idle: assert property (@(posedge clk) disable iff (rst)
    !go |-> (a_deq == '0 && b_deq == '0));

  // R9: stalled output holds
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_unit
      // R2: one side of the mirrored pair
      a_r2_one_side: assert property (@(posedge clk) disable iff (rst)
        go |-> (a_deq[i] != b_deq[W-1-i]));
      // R4: basic mode tie goes to B
      a_r4_tie_b: assert property (@(posedge clk) disable iff (rst)
        (go && !bal_en && a_data[i*DW +: DW] == b_data[(W-1-i)*DW +: DW])
          |-> b_deq[W-1-i]);
    end
    for (i = 0; i < W - 1; i++) begin : g_ord
      // R7: output chunk descending
      a_r7_desc: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_data[i*DW +: DW] >= out_data[(i+1)*DW +: DW]));
    end
  endgenerate
endmodule

bind bank_merge2 bank_merge2_chk #(.W(W), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bal_en    (bal_en),
  .a_data    (a_data),
  .a_valid   (a_valid),
  .a_deq     (a_deq),
  .b_data    (b_data),
  .b_valid   (b_valid),
  .b_deq     (b_deq),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_valid (out_valid)
);

// File: tb/bank_merge2_bench.sv
module bank_merge2_bench;
  localparam int W   = 4;
  localparam int DW  = 8;
  localparam int LG  = 2;
  localparam int LEN = 24;
  localparam int TOT = 2 * LEN;
  localparam int NCH = TOT / W + 2;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            bal_en = 1'b0;
  logic            out_ready = 1'b0;
  logic [W*DW-1:0] a_data = '0;
  logic [W*DW-1:0] b_data = '0;
  logic [W-1:0]    a_valid = '0;
  logic [W-1:0]    b_valid = '0;
  logic [W-1:0]    a_deq, b_deq;
  logic [W*DW-1:0] out_data;
  logic            out_valid;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int la [LEN];
  int lb [LEN];
  int mg [TOT];
  int pa [W];
  int pb [W];
  bit lastb [W];

  always #2 clk = ~clk;

  bank_merge2 #(.W(W), .DW(DW)) u_bank_merge2 (
    .clk(clk), .rst(rst), .bal_en(bal_en),
    .a_data(a_data), .a_valid(a_valid), .a_deq(a_deq),
    .b_data(b_data), .b_valid(b_valid), .b_deq(b_deq),
    .out_ready(out_ready), .out_data(out_data), .out_valid(out_valid)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int head_a(input int i);
    int idx = pa[i] * W + i;
    return (idx < LEN) ? la[idx] : 0;
  endfunction

  function automatic int head_b(input int j);
    int idx = pb[j] * W + j;
    return (idx < LEN) ? lb[idx] : 0;
  endfunction

  task automatic fill(input int kind);
    int va = 250;
    int vb = 248;
    int ia = 0;
    int ib = 0;
    for (int k = 0; k < LEN; k++) begin
      case (kind)
        0: begin
          la[k] = va; va -= int'($urandom % 4);
          lb[k] = vb; vb -= int'($urandom % 4);
        end
        1: begin la[k] = 77; lb[k] = 77; end
        default: begin la[k] = 240 - k; lb[k] = 100 - k; end
      endcase
    end
    for (int k = 0; k < TOT; k++) begin
      if (ib >= LEN || (ia < LEN && la[ia] >= lb[ib])) begin
        mg[k] = la[ia]; ia++;
      end else begin
        mg[k] = lb[ib]; ib++;
      end
    end
  endtask

  task automatic run(input int kind, input bit bal, input bit stall);
    int chunk = 0;
    int cyc = 0;
    int ff = -1;
    int fo = -1;
    bit held = 0;
    bit rdy;
    bit fire;
    logic [W*DW-1:0] pdata = '0;
    logic [W-1:0] ra = '0;
    logic [W-1:0] rb = '0;
    fill(kind);
    bal_en = bal;
    rst = 1'b1;
    a_valid = '0;
    b_valid = '0;
    out_ready = 1'b0;
    for (int i = 0; i < W; i++) begin pa[i] = 0; pb[i] = 0; lastb[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    rst = 1'b0;
    while (chunk < NCH && cyc < 3000) begin
      @(negedge clk);
      for (int i = 0; i < W; i++) begin
        if (ra[i]) pa[i]++;
        if (rb[i]) pb[i]++;
      end
      rdy = !stall || ($urandom % 3 != 0);
      if (out_valid) begin
        if (fo < 0) begin
          fo = cyc;
          chk(fo - ff == LG + 1, "R8 fill latency", fo - ff, LG + 1);
        end
        if (held) chk(out_data == pdata, "R9 held data", int'(out_data), int'(pdata));
        if (rdy) begin
          bit ok = 1;
          int act = 0;
          int exp = 0;
          for (int j = 0; j < W; j++) begin
            int e = (chunk * W + j < TOT) ? mg[chunk * W + j] : 0;
            int g = int'(out_data[j*DW +: DW]);
            if (ok && g != e) begin ok = 0; act = g; exp = e; end
          end
          chk(ok, (chunk * W >= TOT) ? "R10 zero chunk" : "R7 merged chunk", act, exp);
          chunk++;
        end
      end else if (held) begin
        chk(0, "R9 valid dropped during stall", 0, 1);
      end
      out_ready = rdy;
      held = out_valid && !rdy;
      pdata = out_data;
      for (int i = 0; i < W; i++) begin
        a_data[i*DW +: DW] = DW'(head_a(i));
        b_data[i*DW +: DW] = DW'(head_b(i));
        a_valid[i] = ($urandom % 8 != 0);
        b_valid[i] = ($urandom % 8 != 0);
      end
      #1;
      fire = (&a_valid) && (&b_valid) && (!out_valid || rdy);
      if (!fire) begin
        chk(a_deq == '0 && b_deq == '0, "R6 no dequeue", int'({a_deq, b_deq}), 0);
      end else begin
        if (ff < 0) ff = cyc;
        for (int i = 0; i < W; i++) begin
          int ha = head_a(i);
          int hb = head_b(W - 1 - i);
          bit ta = (ha > hb) || (ha == hb && bal && lastb[i]);
          string tag;
          if (ha != hb) tag = "R3 larger head popped";
          else if (bal) tag = "R5 balanced tie";
          else tag = "R4 tie to B";
          chk(a_deq[i] == ta && b_deq[W-1-i] == !ta, tag, int'(a_deq[i]), int'(ta));
          lastb[i] = !ta;
        end
        chk($countones({a_deq, b_deq}) == W, "R2 pop count",
            $countones({a_deq, b_deq}), W);
      end
      ra = a_deq;
      rb = b_deq;
      cyc++;
    end
    chk(chunk == NCH, "R7 chunks delivered", chunk, NCH);
  endtask

  initial begin
    run(0, 0, 0);
    run(0, 1, 1);
    run(1, 0, 0);
    run(1, 1, 0);
    run(2, 0, 1);
    run(2, 1, 0);
    run(0, 0, 1);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #600000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule